// File: doc/BRIEF.md
# Device-to-Host Status Frame Composer

This block assembles the status frames that a SATA host port stores in its
receive area whenever the attached drive reports progress. Three frame kinds
are built: the register frame that closes an ordinary command, the set-up
frame that announces a programmed-I/O data phase, and the short set-device-bits
frame that reports completion of queued commands. The request, the shadow task
file (status, error, the seven address/select bytes), the count bytes of the
current command, the transfer length, the interrupt-pending flag and the mask
of finished slots are captured together when a request is accepted.

The captured frame then leaves as a burst of byte writes, one per clock, into
the port's receive area at a fixed offset per kind, with a done pulse on the
final byte. A set-device-bits frame also ORs the newly finished slots into a
running completion mask that forms its payload, and when it completes the
block refreshes its 16-bit task-file data word. Frames are only produced while
frame reception is switched on and a receive area exists; otherwise the request
is dropped without any side effect.

Top module: `stfis_composer`

## Requirements
- R1: A request made while `rx_enable` or `area_valid` is low is dropped: no write, no `frame_done`, the completion mask does not absorb `done_slots`, and `tfd_word` keeps its value.
- R2: `req_kind` encodes 0 = register frame, 1 = programmed-I/O set-up frame, 2 = set-device-bits frame; code 3 is ignored, and a request is taken only while `busy` is low, so requests during a burst have no effect.
- R3: An accepted frame is written in the cycles right after acceptance, one byte per clock on consecutive addresses starting at offset 0x40 (register, 20 bytes), 0x20 (set-up, 20 bytes) or 0x58 (set-device-bits, 8 bytes); `frame_done` is high with the last byte only and `busy` covers exactly the write cycles.
- R4: Byte 0 is the type code: 0x34 register, 0x5F set-up, 0xA1 set-device-bits.
- R5: Byte 1 is 0x40 when `irq_pending` was high at acceptance and 0x00 otherwise, for every kind.
- R6: In register and set-up frames byte 2 is status, byte 3 is error, bytes 4 to 10 are `tf_addr` bytes 0 to 6 (byte k of `tf_addr` is bits 8k+7:8k), and byte 11 is 0.
- R7: In register and set-up frames bytes 12 and 13 are `cmd_count[7:0]` and `cmd_count[15:8]`.
- R8: In the set-up frame byte 14 is 0, byte 15 repeats status, bytes 16 and 17 are `xfer_len` low then high, and bytes 18 and 19 are 0.
- R9: In the register frame bytes 14 to 19 are 0.
- R10: The set-device-bits frame is: type, flags, status AND 0x77, error, then the 32-bit completion mask least significant byte first.
- R11: The completion mask is the OR of `done_slots` over every accepted set-device-bits request since reset, including the current one.
- R12: One cycle after the last byte of a set-device-bits frame, `tfd_word` equals {error, status} of that frame; the other kinds leave it unchanged; it is 0 after reset.
- R13: All frame content is fixed at acceptance; input changes during a burst do not alter the bytes written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Frame reception switched on |
| area_valid | input | 1 | A receive area has been assigned |
| req_valid | input | 1 | Frame request |
| req_kind | input | 2 | Frame kind (0 register, 1 set-up, 2 set-device-bits) |
| tf_status | input | 8 | Shadow status byte |
| tf_error | input | 8 | Shadow error byte |
| tf_addr | input | 56 | Sector, low/high cylinder, select, three high-order address bytes (byte 0 first) |
| cmd_count | input | 16 | Count bytes of the current command frame |
| xfer_len | input | 16 | Programmed-I/O transfer length |
| irq_pending | input | 1 | Controller interrupt status is nonzero |
| done_slots | input | 32 | Slots finished since the last report |
| busy | output | 1 | Burst in progress |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 8 | Byte offset in the receive area |
| wr_data | output | 8 | Byte written |
| frame_done | output | 1 | Last byte of the frame |
| tfd_word | output | 16 | Task-file data word |

## Verification
Each frame kind is driven with random task-file bytes, counts, lengths and interrupt flags, which separates byte-position mistakes from field swaps because every field carries a different value. Set-device-bits frames are chained with overlapping and disjoint slot masks to tell a running OR apart from a plain copy, and with status values that have the busy and data-request bits set to expose a missing mask. Dropped requests (reception off, no area, kind 3, a request during a burst) are followed by a normal frame whose payload and task-file word reveal any leaked side effect, and inputs are scrambled during every burst to catch content not held from acceptance.

// File: rtl/stfis_pkg.sv
package stfis_pkg;

    typedef enum logic [1:0] {
        KIND_REG = 2'd0,
        KIND_PIO = 2'd1,
        KIND_SDB = 2'd2,
        KIND_BAD = 2'd3
    } kind_e;

    localparam int IDX_W     = 5;
    localparam int SLOT_N    = 32;
    localparam int LONG_LEN  = 20;
    localparam int SHORT_LEN = 8;

    localparam logic [7:0] TYPE_REG = 8'h34;
    localparam logic [7:0] TYPE_PIO = 8'h5F;
    localparam logic [7:0] TYPE_SDB = 8'hA1;
    localparam logic [7:0] SDB_STAT_MASK = 8'h77;
    localparam logic [7:0] FLAG_IRQ = 8'h40;

    typedef struct packed {
        kind_e              kind;
        logic [7:0]         status;
        logic [7:0]         error;
        logic [55:0]        addr;
        logic [15:0]        count;
        logic [15:0]        xlen;
        logic               irq;
        logic [SLOT_N-1:0]  payload;
    } snap_t;

    function automatic logic [IDX_W-1:0] frame_len(kind_e k);
        return (k == KIND_SDB) ? IDX_W'(SHORT_LEN) : IDX_W'(LONG_LEN);
    endfunction

    function automatic logic [7:0] type_code(kind_e k);
        case (k)
            KIND_REG: return TYPE_REG;
            KIND_PIO: return TYPE_PIO;
            default:  return TYPE_SDB;
        endcase
    endfunction

    function automatic logic [7:0] short_byte(snap_t s, logic [IDX_W-1:0] i);
        logic [7:0] b;
        case (i)
            5'd0:    b = TYPE_SDB;
            5'd1:    b = s.irq ? FLAG_IRQ : 8'h00;
            5'd2:    b = s.status & SDB_STAT_MASK;
            5'd3:    b = s.error;
            5'd4:    b = s.payload[7:0];
            5'd5:    b = s.payload[15:8];
            5'd6:    b = s.payload[23:16];
            5'd7:    b = s.payload[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] long_byte(snap_t s, logic [IDX_W-1:0] i);
        logic [7:0] b;
        logic       pio;
        pio = (s.kind == KIND_PIO);
        case (i)
            5'd0:    b = type_code(s.kind);
            5'd1:    b = s.irq ? FLAG_IRQ : 8'h00;
            5'd2:    b = s.status;
            5'd3:    b = s.error;
            5'd4:    b = s.addr[7:0];
            5'd5:    b = s.addr[15:8];
            5'd6:    b = s.addr[23:16];
            5'd7:    b = s.addr[31:24];
            5'd8:    b = s.addr[39:32];
            5'd9:    b = s.addr[47:40];
            5'd10:   b = s.addr[55:48];
            5'd12:   b = s.count[7:0];
            5'd13:   b = s.count[15:8];
            5'd15:   b = pio ? s.status : 8'h00;
            5'd16:   b = pio ? s.xlen[7:0] : 8'h00;
            5'd17:   b = pio ? s.xlen[15:8] : 8'h00;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/stfis_accum.sv
module stfis_accum
    import stfis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [SLOT_N-1:0] slots_in,
    input  logic              tfd_load,
    input  logic [7:0]        tfd_status,
    input  logic [7:0]        tfd_error,
    output logic [SLOT_N-1:0] mask_next,
    output logic [15:0]       tfd_q
);
    logic [SLOT_N-1:0] mask_q;

    assign mask_next = mask_q | slots_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            tfd_q  <= '0;
        end else begin
            if (take) begin
                mask_q <= mask_next;
            end
            if (tfd_load) begin
                tfd_q <= {tfd_error, tfd_status};
            end
        end
    end
endmodule

// File: rtl/stfis_seq.sv
module stfis_seq
    import stfis_pkg::*;
#(
    parameter int AW = 8,
    parameter int REG_OFS = 8'h40,
    parameter int PIO_OFS = 8'h20,
    parameter int SDB_OFS = 8'h58
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_ok,
    input  logic             req_valid,
    input  kind_e            req_kind,
    input  snap_t            snap_in,
    output logic             accept,
    output snap_t            snap_q,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             last,
    output logic [AW-1:0]    addr
);
    typedef enum logic {ST_IDLE, ST_EMIT} st_e;

    st_e              st_q;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    base;

    assign accept = (st_q == ST_IDLE) && req_valid && gate_ok
                    && (req_kind != KIND_BAD);
    assign busy   = (st_q == ST_EMIT);
    assign last   = busy && (idx_q == frame_len(snap_q.kind) - 5'd1);
    assign idx    = idx_q;

    always_comb begin
        case (snap_q.kind)
            KIND_REG: base = AW'(REG_OFS);
            KIND_PIO: base = AW'(PIO_OFS);
            default:  base = AW'(SDB_OFS);
        endcase
    end

    assign addr = base + AW'(idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            snap_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (accept) begin
                        snap_q <= snap_in;
                        st_q   <= ST_EMIT;
                    end
                end
                default: begin
                    if (last) begin
                        st_q  <= ST_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 5'd1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/stfis_bytegen.sv
module stfis_bytegen
    import stfis_pkg::*;
(
    input  snap_t            snap,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    always_comb begin
        if (snap.kind == KIND_SDB) begin
            data = short_byte(snap, idx);
        end else begin
            data = long_byte(snap, idx);
        end
    end
endmodule

// File: rtl/stfis_composer.sv
module stfis_composer
    import stfis_pkg::*;
#(
    parameter int AW = 8,
    parameter int REG_OFS = 8'h40,
    parameter int PIO_OFS = 8'h20,
    parameter int SDB_OFS = 8'h58
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_enable,
    input  logic          area_valid,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [7:0]    tf_status,
    input  logic [7:0]    tf_error,
    input  logic [55:0]   tf_addr,
    input  logic [15:0]   cmd_count,
    input  logic [15:0]   xfer_len,
    input  logic          irq_pending,
    input  logic [31:0]   done_slots,
    output logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          frame_done,
    output logic [15:0]   tfd_word
);
    kind_e            kind_in;
    snap_t            snap_in;
    snap_t            snap_q;
    logic             accept;
    logic             last;
    logic [IDX_W-1:0] idx;
    logic [SLOT_N-1:0] mask_next;

    assign kind_in = kind_e'(req_kind);

    always_comb begin
        snap_in.kind    = kind_in;
        snap_in.status  = tf_status;
        snap_in.error   = tf_error;
        snap_in.addr    = tf_addr;
        snap_in.count   = cmd_count;
        snap_in.xlen    = xfer_len;
        snap_in.irq     = irq_pending;
        snap_in.payload = mask_next;
    end

    stfis_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .take       (accept && (kind_in == KIND_SDB)),
        .slots_in   (done_slots),
        .tfd_load   (last && (snap_q.kind == KIND_SDB)),
        .tfd_status (snap_q.status),
        .tfd_error  (snap_q.error),
        .mask_next  (mask_next),
        .tfd_q      (tfd_word)
    );

    stfis_seq #(
        .AW(AW), .REG_OFS(REG_OFS), .PIO_OFS(PIO_OFS), .SDB_OFS(SDB_OFS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .gate_ok   (rx_enable && area_valid),
        .req_valid (req_valid),
        .req_kind  (kind_in),
        .snap_in   (snap_in),
        .accept    (accept),
        .snap_q    (snap_q),
        .idx       (idx),
        .busy      (busy),
        .last      (last),
        .addr      (wr_addr)
    );

    stfis_bytegen u_bytes (
        .snap (snap_q),
        .idx  (idx),
        .data (wr_data)
    );

    assign wr_en      = busy;
    assign frame_done = last;
endmodule

// File: rtl/stfis_checker.sv
module stfis_checker #(
    parameter int AW = 8,
    parameter int SDB_OFS = 8'h58
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_enable,
    input logic          area_valid,
    input logic          busy,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          frame_done,
    input logic [15:0]   tfd_word
);
    // R1: with reception gated off while idle, no write follows
    a_r1_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(rx_enable && area_valid)) |=> !wr_en);

    // R3: bytes go to consecutive addresses until the done pulse
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !frame_done) |=> (wr_en && wr_addr == $past(wr_addr) + AW'(1)));

    // R3: done only together with a write
    a_r3_done_in_burst: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> wr_en);

    // R3: busy drops right after the last byte
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !busy);

    // R4: first byte of a burst is a known type code
    a_r4_type_first: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> (wr_data == 8'h34 || wr_data == 8'h5F || wr_data == 8'hA1));

    // R10: reported status in the short frame never carries BSY or DRQ
    a_r10_status_masked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(SDB_OFS + 2)) |-> (wr_data[7] == 1'b0 && wr_data[3] == 1'b0));

    // R12: task-file word moves only after a done pulse
    a_r12_tfd_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(tfd_word));
endmodule

bind stfis_composer stfis_checker #(.AW(AW), .SDB_OFS(SDB_OFS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_enable  (rx_enable),
    .area_valid (area_valid),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_done (frame_done),
    .tfd_word   (tfd_word)
);

// File: tb/stfis_composer_bench.sv
module stfis_composer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b1;
    logic        area_valid = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  tf_status = 8'h00;
    logic [7:0]  tf_error = 8'h00;
    logic [55:0] tf_addr = '0;
    logic [15:0] cmd_count = '0;
    logic [15:0] xfer_len = '0;
    logic        irq_pending = 1'b0;
    logic [31:0] done_slots = '0;
    logic        busy, wr_en, frame_done;
    logic [7:0]  wr_addr, wr_data;
    logic [15:0] tfd_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_mask = '0;
    logic [15:0] exp_tfd = '0;
    logic [7:0]  ef [20];

    always #(CLK_PERIOD/2) clk = ~clk;

    stfis_composer u_stfis_composer (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .area_valid(area_valid),
        .req_valid(req_valid), .req_kind(req_kind), .tf_status(tf_status),
        .tf_error(tf_error), .tf_addr(tf_addr), .cmd_count(cmd_count),
        .xfer_len(xfer_len), .irq_pending(irq_pending), .done_slots(done_slots),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_done(frame_done), .tfd_word(tfd_word)
    );

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int flen(logic [1:0] k);
        return (k == 2'd2) ? 8 : 20;
    endfunction

    function automatic logic [7:0] fbase(logic [1:0] k);
        return (k == 2'd0) ? 8'h40 : (k == 2'd1) ? 8'h20 : 8'h58;
    endfunction

    // expected frame from the current inputs (mask already updated)
    task automatic build_expected(logic [1:0] k);
        for (int i = 0; i < 20; i++) ef[i] = 8'h00;
        ef[1] = irq_pending ? 8'h40 : 8'h00;
        ef[3] = tf_error;
        if (k == 2'd2) begin
            ef[0] = 8'hA1;
            ef[2] = tf_status & 8'h77;
            for (int b = 0; b < 4; b++) ef[4+b] = exp_mask[8*b +: 8];
        end else begin
            ef[0] = (k == 2'd0) ? 8'h34 : 8'h5F;
            ef[2] = tf_status;
            for (int b = 0; b < 7; b++) ef[4+b] = tf_addr[8*b +: 8];
            ef[12] = cmd_count[7:0];
            ef[13] = cmd_count[15:8];
            if (k == 2'd1) begin
                ef[15] = tf_status;
                ef[16] = xfer_len[7:0];
                ef[17] = xfer_len[15:8];
            end
        end
    endtask

    task automatic scramble();
        tf_status   = 8'($urandom);
        tf_error    = 8'($urandom);
        tf_addr     = {24'($urandom), 32'($urandom)};
        cmd_count   = 16'($urandom);
        xfer_len    = 16'($urandom);
        irq_pending = 1'($urandom);
        done_slots  = $urandom;
    endtask

    // inputs already set; issue at negedge, check the whole burst
    task automatic run_frame(logic [1:0] k);
        string tag;
        @(negedge clk);
        if (k == 2'd2) exp_mask = exp_mask | done_slots;
        build_expected(k);
        req_kind  = k;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 2'd2) begin
            exp_tfd = {tf_error, tf_status};
        end
        scramble();                                   // R13: late changes ignored
        for (int i = 0; i < flen(k); i++) begin
            if (i == 3) begin req_valid = 1'b1; req_kind = 2'd1; end  // R2: ignored while busy
            if (i == flen(k) - 1) req_valid = 1'b0;
            tag = (i == 0) ? "R4" : (i == 1) ? "R5" : (k == 2'd2) ? "R10" :
                  (i < 12) ? "R6" : (i < 14) ? "R7" : (k == 2'd1) ? "R8" : "R9";
            check("R3 write strobe", 64'(wr_en), 64'(1));
            check("R3 address", 64'(wr_addr), 64'(fbase(k) + 8'(i)));
            check("R3 done pulse", 64'(frame_done), 64'(i == flen(k) - 1));
            check({tag, " R13 byte"}, 64'(wr_data), 64'(ef[i]));
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R3 idle after burst", 64'({busy, wr_en}), 64'(0));
        check("R12 tfd word", 64'(tfd_word), 64'(exp_tfd));
    endtask

    task automatic expect_silence(string req, int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check(req, 64'({busy, wr_en, frame_done}), 64'(0));
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R3 reset busy", 64'({busy, wr_en, frame_done}), 64'(0));
        check("R12 reset tfd", 64'(tfd_word), 64'(0));

        // directed: each kind once
        scramble(); irq_pending = 1'b1; run_frame(2'd0);
        scramble(); irq_pending = 1'b0; run_frame(2'd1);
        scramble(); tf_status = 8'hFF; done_slots = 32'h0000_0005; run_frame(2'd2);
        scramble(); done_slots = 32'h8000_0004; run_frame(2'd2);   // R11 overlap/disjoint

        // R1: reception off, then no area
        scramble(); rx_enable = 1'b0; done_slots = 32'h00F0_0000;
        req_kind = 2'd2; req_valid = 1'b1;
        expect_silence("R1 reception off", 4);
        req_valid = 1'b0; rx_enable = 1'b1; area_valid = 1'b0;
        @(negedge clk); req_kind = 2'd0; req_valid = 1'b1;
        expect_silence("R1 no area", 4);
        req_valid = 1'b0; area_valid = 1'b1;
        check("R1 tfd kept", 64'(tfd_word), 64'(exp_tfd));
        // R2: kind 3 ignored
        @(negedge clk); req_kind = 2'd3; req_valid = 1'b1;
        expect_silence("R2 kind 3", 3);
        req_valid = 1'b0;
        // R1/R11: dropped slots never reach the mask
        scramble(); done_slots = 32'h0; run_frame(2'd2);

        // R12: other kinds leave tfd alone
        scramble(); run_frame(2'd0);

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [1:0] k;
            k = 2'($urandom_range(0, 2));
            scramble();
            run_frame(k);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule